// File: doc/BRIEF.md
# SYSREF Phase Monitor with Multiframe Counter

This block keeps the local frame and multiframe phase of a serial data link transmitter and judges every SYSREF event against it. Two free-running counters, clocked by the device clock, mark the start of every frame and of every multiframe with one-cycle strobes. The transmit framer and the link controller use these strobes as their timing grid.

SYSREF is asynchronous to the block, so it is first resynchronized, and only its rising edge counts as an event. The event is judged in two steps. If the multiframe counter is already at phase zero, nothing happens. If it is not, the block checks the frame counter. A frame phase that still matches is tolerated and no counter moves. A frame phase that is also off restarts both counters at the SYSREF phase, pulses a realign flag, and raises a one-cycle link reinitialization request on the first multiframe boundary of the new grid. While the calibration-busy input is high, events are dropped. A sticky status code reports the outcome of the last event that was acted on.

Top module: `sysref_phase_monitor`

## Requirements
- R1: SYSREF goes through a two-flop synchronizer. An input first sampled high at clock edge k is judged against the counter phase present in the cycle that follows edge k+1.
- R2: Only a low-to-high transition of the synchronized SYSREF is an event. An input held high yields exactly one event, and a falling transition changes no output.
- R3: After reset both counters are at phase zero. `frame_strobe` is high once every CLKS_PER_FRAME cycles and `lmfc_strobe` is high once every CLKS_PER_FRAME*FRAMES_PER_MF cycles, always together with `frame_strobe`.
- R4: An event judged while both counters are at zero leaves the phase unchanged, gives no realign and no reinit request, and sets `event_status` to 1.
- R5: An event judged with the multiframe phase nonzero but the frame phase zero leaves both counters unchanged and gives no realign and no reinit request. It sets `event_status` to 2.
- R6: An event judged with the frame phase nonzero restarts both counters so that the judging cycle becomes phase zero. The next `lmfc_strobe` comes CLKS_PER_FRAME*FRAMES_PER_MF cycles after that cycle. `realign_pulse` is high for the one cycle after it, and `event_status` becomes 3.
- R7: After a realignment, `reinit_req` is high for exactly one cycle, on the first `lmfc_strobe` of the new grid, and is low at all other times.
- R8: An event judged while `cal_busy` is high is dropped. The phase, `event_status`, `realign_pulse` and `reinit_req` stay unchanged.
- R9: `event_status` is 0 after reset and holds its last value until another event is acted on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Device clock |
| rst | input | 1 | Synchronous active-high reset |
| sysref_in | input | 1 | Asynchronous SYSREF alignment input |
| cal_busy | input | 1 | High while power-up or calibration is in progress; events are dropped |
| frame_strobe | output | 1 | High in the cycle where the frame phase is zero |
| lmfc_strobe | output | 1 | High in the cycle where both frame and multiframe phases are zero |
| realign_pulse | output | 1 | One-cycle pulse after the counters were restarted |
| reinit_req | output | 1 | One-cycle link reinitialization request on the first new multiframe boundary |
| event_status | output | 2 | Sticky outcome: 0 none, 1 aligned, 2 frame matched, 3 realigned |

## Verification
A wrong counter state shows up at the strobes. A phase that was shifted when it should have been kept moves the next `lmfc_strobe` away from the expected cycle, so the fault is visible within one multiframe. A misjudged event shows one cycle later: `realign_pulse` is wrong or the status code is wrong. A lost or misplaced pending request shows up when `reinit_req` is missing on, or appears away from, the first new boundary.

// File: rtl/sysref_mon_pkg.sv
package sysref_mon_pkg;

    typedef enum logic [1:0] {
        EVT_NONE      = 2'd0,
        EVT_ALIGNED   = 2'd1,
        EVT_LMFC_SLIP = 2'd2,
        EVT_REALIGNED = 2'd3
    } evt_status_e;

    typedef enum logic [1:0] {
        DEC_IGNORE,
        DEC_KEEP_ALIGNED,
        DEC_KEEP_SLIP,
        DEC_REALIGN
    } decision_e;

    typedef struct packed {
        logic frame_zero;
        logic lmfc_zero;
    } phase_flags_t;

    function automatic int unsigned cnt_w(input int unsigned n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

    // Two-level judgement: multiframe phase first, frame phase second.
    function automatic decision_e classify(input logic ev, input logic busy,
                                           input phase_flags_t f);
        if (!ev || busy)  return DEC_IGNORE;
        if (f.lmfc_zero)  return DEC_KEEP_ALIGNED;
        if (f.frame_zero) return DEC_KEEP_SLIP;
        return DEC_REALIGN;
    endfunction

endpackage

// File: rtl/sysref_sync.sv
module sysref_sync
    import sysref_mon_pkg::*;
#(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic async_i,
    output logic rise_o
);
    logic [STAGES-1:0] chain_q;
    logic              last_q;

    always_ff @(posedge clk) begin
        if (rst) chain_q[0] <= 1'b0;
        else     chain_q[0] <= async_i;
    end

    generate
        for (genvar s = 1; s < STAGES; s++) begin : g_stage
            always_ff @(posedge clk) begin
                if (rst) chain_q[s] <= 1'b0;
                else     chain_q[s] <= chain_q[s-1];
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) last_q <= 1'b0;
        else     last_q <= chain_q[STAGES-1];
    end

    assign rise_o = chain_q[STAGES-1] & ~last_q;

    AST_RISE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        rise_o |=> !rise_o);  // R2

endmodule

// File: rtl/phase_counters.sv
module phase_counters
    import sysref_mon_pkg::*;
#(
    parameter int unsigned CLKS_PER_FRAME = 4,
    parameter int unsigned FRAMES_PER_MF  = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load_i,
    output phase_flags_t flags_o
);
    localparam int unsigned FC_W = cnt_w(CLKS_PER_FRAME);
    localparam int unsigned MC_W = cnt_w(FRAMES_PER_MF);
    localparam logic [FC_W-1:0] FC_LAST = FC_W'(CLKS_PER_FRAME - 1);
    localparam logic [MC_W-1:0] MC_LAST = MC_W'(FRAMES_PER_MF - 1);
    // Phase one cycle after phase zero: used when the event cycle becomes zero.
    localparam logic [FC_W-1:0] FC_LOAD = (CLKS_PER_FRAME > 1) ? FC_W'(1) : '0;
    localparam logic [MC_W-1:0] MC_LOAD =
        (CLKS_PER_FRAME > 1 || FRAMES_PER_MF == 1) ? '0 : MC_W'(1);

    logic [FC_W-1:0] fc_q;
    logic [MC_W-1:0] mc_q;
    logic            frame_wrap;

    assign frame_wrap = (fc_q == FC_LAST);

    always_ff @(posedge clk) begin
        if (rst) begin
            fc_q <= '0;
        end else if (load_i) begin
            fc_q <= FC_LOAD;
        end else if (frame_wrap) begin
            fc_q <= '0;
        end else begin
            fc_q <= fc_q + FC_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mc_q <= '0;
        end else if (load_i) begin
            mc_q <= MC_LOAD;
        end else if (frame_wrap) begin
            mc_q <= (mc_q == MC_LAST) ? '0 : mc_q + MC_W'(1);
        end
    end

    assign flags_o.frame_zero = (fc_q == '0);
    assign flags_o.lmfc_zero  = (fc_q == '0) && (mc_q == '0);

    AST_FRAME_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
        fc_q <= FC_LAST);  // R3
    AST_MF_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
        mc_q <= MC_LAST);  // R3

endmodule

// File: rtl/align_judge.sv
module align_judge
    import sysref_mon_pkg::*;
(
    input  logic         clk,
    input  logic         rst,
    input  logic         event_i,
    input  logic         busy_i,
    input  phase_flags_t flags_i,
    output logic         load_o,
    output logic         realign_pulse_o,
    output logic         reinit_req_o,
    output evt_status_e  status_o
);
    decision_e dec;
    logic      pending_q;

    assign dec    = classify(event_i, busy_i, flags_i);
    assign load_o = (dec == DEC_REALIGN);

    always_ff @(posedge clk) begin
        if (rst) begin
            status_o        <= EVT_NONE;
            realign_pulse_o <= 1'b0;
        end else begin
            realign_pulse_o <= (dec == DEC_REALIGN);
            unique case (dec)
                DEC_KEEP_ALIGNED: status_o <= EVT_ALIGNED;
                DEC_KEEP_SLIP:    status_o <= EVT_LMFC_SLIP;
                DEC_REALIGN:      status_o <= EVT_REALIGNED;
                default:          status_o <= status_o;
            endcase
        end
    end

    // A realignment arms the request; the first new multiframe boundary fires it.
    always_ff @(posedge clk) begin
        if (rst)                            pending_q <= 1'b0;
        else if (load_o)                    pending_q <= 1'b1;
        else if (pending_q && flags_i.lmfc_zero) pending_q <= 1'b0;
    end

    assign reinit_req_o = pending_q & flags_i.lmfc_zero;

    AST_BUSY_NO_REALIGN: assert property (@(posedge clk) disable iff (rst)
        (event_i && busy_i) |=> !realign_pulse_o);  // R8
    AST_REALIGN_STATUS: assert property (@(posedge clk) disable iff (rst)
        realign_pulse_o |-> (status_o == EVT_REALIGNED));  // R6
    AST_REINIT_AT_BOUNDARY: assert property (@(posedge clk) disable iff (rst)
        reinit_req_o |-> flags_i.lmfc_zero);  // R7
    AST_REINIT_SINGLE: assert property (@(posedge clk) disable iff (rst)
        reinit_req_o |=> !reinit_req_o);  // R7
    AST_REALIGN_SINGLE: assert property (@(posedge clk) disable iff (rst)
        realign_pulse_o |=> !realign_pulse_o);  // R2

endmodule

// File: rtl/sysref_phase_monitor.sv
module sysref_phase_monitor
    import sysref_mon_pkg::*;
#(
    parameter int unsigned CLKS_PER_FRAME = 4,
    parameter int unsigned FRAMES_PER_MF  = 8,
    parameter int unsigned SYNC_STAGES    = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       sysref_in,
    input  logic       cal_busy,
    output logic       frame_strobe,
    output logic       lmfc_strobe,
    output logic       realign_pulse,
    output logic       reinit_req,
    output logic [1:0] event_status
);
    logic         sysref_rise;
    logic         load;
    phase_flags_t flags;
    evt_status_e  status;

    sysref_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst     (rst),
        .async_i (sysref_in),
        .rise_o  (sysref_rise)
    );

    phase_counters #(
        .CLKS_PER_FRAME (CLKS_PER_FRAME),
        .FRAMES_PER_MF  (FRAMES_PER_MF)
    ) u_counters (
        .clk     (clk),
        .rst     (rst),
        .load_i  (load),
        .flags_o (flags)
    );

    align_judge u_judge (
        .clk             (clk),
        .rst             (rst),
        .event_i         (sysref_rise),
        .busy_i          (cal_busy),
        .flags_i         (flags),
        .load_o          (load),
        .realign_pulse_o (realign_pulse),
        .reinit_req_o    (reinit_req),
        .status_o        (status)
    );

    assign frame_strobe = flags.frame_zero;
    assign lmfc_strobe  = flags.lmfc_zero;
    assign event_status = status;

    AST_LMFC_ON_FRAME: assert property (@(posedge clk) disable iff (rst)
        lmfc_strobe |-> frame_strobe);  // R3
    AST_NO_REALIGN_IN_CAL: assert property (@(posedge clk) disable iff (rst)
        (cal_busy && $stable(cal_busy) && $past(cal_busy)) |-> !load);  // R8

endmodule

// File: tb/sysref_phase_monitor_bench.sv
module sysref_phase_monitor_bench;
    localparam int CPF = 4;
    localparam int FPM = 8;
    localparam int L   = CPF * FPM;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       sysref_in = 1'b0;
    logic       cal_busy = 1'b0;
    logic       frame_strobe, lmfc_strobe, realign_pulse, reinit_req;
    logic [1:0] event_status;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    sysref_phase_monitor #(.CLKS_PER_FRAME(CPF), .FRAMES_PER_MF(FPM)) u_sysref_phase_monitor (
        .clk           (clk),
        .rst           (rst),
        .sysref_in     (sysref_in),
        .cal_busy      (cal_busy),
        .frame_strobe  (frame_strobe),
        .lmfc_strobe   (lmfc_strobe),
        .realign_pulse (realign_pulse),
        .reinit_req    (reinit_req),
        .event_status  (event_status)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic wait_lmfc();
        do @(negedge clk); while (!lmfc_strobe);
    endtask

    // Raise SYSREF so that it is judged `offset` cycles after an LMFC boundary.
    task automatic run_event(input string req, input int offset, input bit busy,
                             input int exp_st, input bit exp_re);
        int n;
        bit stray;
        wait_lmfc();
        repeat (L - 2 + offset) @(negedge clk);
        sysref_in = 1'b1;
        cal_busy  = busy;
        repeat (2) @(negedge clk);              // judging cycle
        @(negedge clk);                          // one cycle later
        check(realign_pulse == exp_re, req, "realign_pulse", realign_pulse, exp_re);
        check(event_status == exp_st, req, "event_status", event_status, exp_st);
        n = 1;
        stray = 0;
        while (!lmfc_strobe && n < 2 * L) begin
            if (reinit_req) stray = 1;
            @(negedge clk);
            n++;
        end
        check(n == (exp_re ? L : L - offset), req, "cycles to next lmfc_strobe",
              n, exp_re ? L : L - offset);
        check(reinit_req == exp_re, "R7", "reinit_req at boundary", reinit_req, exp_re);
        check(!stray, "R7", "reinit_req before boundary", stray, 0);
        @(negedge clk);
        check(!reinit_req, "R7", "reinit_req after boundary", reinit_req, 0);
        sysref_in = 1'b0;
        cal_busy  = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    task automatic test_reset();
        int n;
        repeat (3) @(negedge clk);
        check(frame_strobe && lmfc_strobe, "R3", "strobes in reset",
              {frame_strobe, lmfc_strobe}, 3);
        check(event_status == 0, "R9", "status after reset", event_status, 0);
        check(!realign_pulse && !reinit_req, "R9", "pulses after reset",
              {realign_pulse, reinit_req}, 0);
        rst = 1'b0;
        n = 0;
        do begin @(negedge clk); n++; end while (!frame_strobe);
        check(n == CPF, "R3", "frame_strobe period", n, CPF);
        n = 0;
        do begin @(negedge clk); n++; end while (!lmfc_strobe);
        check(n == L - CPF, "R3", "first lmfc after reset", n, L - CPF);
        n = 0;
        do begin @(negedge clk); n++; end while (!lmfc_strobe);
        check(n == L, "R3", "lmfc_strobe period", n, L);
    endtask

    task automatic test_held_and_fall();
        int pulses;
        wait_lmfc();
        repeat (L - 2 + 5) @(negedge clk);
        sysref_in = 1'b1;
        repeat (3) @(negedge clk);
        check(realign_pulse == 1'b1, "R2", "first rise realigns", realign_pulse, 1);
        pulses = 0;
        repeat (3 * L) begin
            @(negedge clk);
            if (realign_pulse) pulses++;
        end
        check(pulses == 0, "R2", "pulses while held high", pulses, 0);
        repeat (7) @(negedge clk);
        sysref_in = 1'b0;                        // falling edge at a misaligned phase
        pulses = 0;
        repeat (2 * L) begin
            @(negedge clk);
            if (realign_pulse || reinit_req) pulses++;
        end
        check(pulses == 0, "R2", "pulses after falling edge", pulses, 0);
        check(event_status == 3, "R2", "status after falling edge", event_status, 3);
    endtask

    initial begin
        #(5.0 * 200000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        test_reset();                              // R3 R9
        run_event("R4", 0, 1'b0, 1, 1'b0);         // aligned
        run_event("R5", 3 * CPF, 1'b0, 2, 1'b0);   // frame matches, LMFC off
        run_event("R8", 1, 1'b1, 2, 1'b0);         // busy: dropped, status kept
        run_event("R6", 1, 1'b0, 3, 1'b1);         // R1 timing of judging cycle
        run_event("R4", 0, 1'b0, 1, 1'b0);         // aligned to new grid
        test_held_and_fall();                      // R2
        run_event("R6", 2 * CPF + 3, 1'b0, 3, 1'b1);
        run_event("R9", CPF, 1'b1, 3, 1'b0);       // sticky through dropped event
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule